// File: doc/BRIEF.md
# Two-Wire Register Target with Auto-Increment Pointer

This block is a two-wire serial bus target that maps a bank of byte registers behind one fixed 7-bit device address. A controller selects the device with an address byte. If the direction bit is 0, the next byte sets an internal register pointer and any further bytes are stored at consecutive locations. If the direction bit is 1, the target returns bytes starting at whatever the pointer currently holds. The pointer stays valid between transactions, so a read can begin without first writing an address.

Both bus lines are sampled through two-flop synchronisers and decoded in the system clock domain. The target never drives SCL. On SDA it only pulls the line low, through a drive-enable output, and reads the resolved line back on a separate input. The block also raises a hold output while an addressed transaction has the pointer inside the lower half of the bank (the time-keeping registers). Surrounding logic uses it to freeze its snapshot of the running time. Hold drops on STOP, or as soon as the pointer moves into the upper half.

Top module: `i2c_regfile_target`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal 7'h68 (byte D0h for a write, D1h for a read). Any other address gets no acknowledge, and SDA is left released until the next START.
- R2: In a write transaction, the first byte after the address loads the pointer from its low 4 bits. Each later byte is stored at the pointer location and then read back unchanged.
- R3: The pointer advances by exactly one on each acknowledge clock that follows a data byte, in both directions, and wraps from 4'hF to 4'h0. Loading it from the word-address byte is the only other way it changes.
- R4: A read that starts with no pointer write first returns the register at the pointer value left by the previous transaction.
- R5: A read returns consecutive registers, MSB first, for as long as the controller acknowledges. After a not-acknowledge, the target releases SDA and does not drive it again until a START.
- R6: START (SDA falling while SCL is high) aborts any partial byte and restarts address reception, including as a repeated START. STOP (SDA rising while SCL is high) returns the target to idle.
- R7: `hold_o` is 1 while an addressed transaction is open and the pointer is in 0..7. It is 0 after STOP, and 0 when the pointer is in 8..15.
- R8: Every byte the target receives (device address, word address, data) is acknowledged by pulling SDA low for the whole ninth clock.
- R9: After reset, SDA is released, `hold_o` is 0, the pointer is 0 and all registers read as 8'h00.
- R10: The target changes its SDA drive only while SCL is low. The only exception is releasing the line on a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line, sampled asynchronously |
| sda_i | input | 1 | Resolved bus data line, sampled asynchronously |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| hold_o | output | 1 | Freeze request for the time snapshot |

## Verification
Some properties are checked on every cycle:
- SDA drive changes only while the synchronised SCL is low.
- The pointer either loads from a word-address byte or steps by exactly one with wrap.
- START always lands in address reception with SDA released.
- STOP always clears hold.
- A not-acknowledge always releases SDA.

Other behaviour needs whole transactions, so only the bench scenarios can show it:
- Data actually lands at the right register and comes back on read.
- The pointer carries over into a read that has no address phase.
- A foreign address is ignored.
- A truncated byte is discarded by a repeated START.
- Hold follows the pointer as a write burst crosses from the clock range into the upper registers.

// File: rtl/i2c_tgt_pkg.sv
`timescale 1ns/1ps
package i2c_tgt_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WADR,
    ST_WADR_ACK,
    ST_WDAT,
    ST_WDAT_ACK,
    ST_RDAT,
    ST_RDAT_ACK
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
`timescale 1ns/1ps
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_o      = scl_pipe[STAGES-1];
  assign sda_o      = sda_pipe[STAGES-1];
  assign scl_rise_o = scl_o & ~scl_q;
  assign scl_fall_o = ~scl_o & scl_q;
  // line events only count while SCL stays high across both samples
  assign start_o    = scl_o & scl_q & sda_q & ~sda_o;
  assign stop_o     = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_tgt_regfile.sv
`timescale 1ns/1ps
module i2c_tgt_regfile #(
  parameter int NUM_REGS = 16,
  parameter int DATA_W   = 8,
  localparam int PTR_W   = $clog2(NUM_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [PTR_W-1:0]  waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PTR_W-1:0]  raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [NUM_REGS-1:0] wen;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wen
    assign wen[g] = we_i && (waddr_i == PTR_W'(g));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else begin
      for (int i = 0; i < NUM_REGS; i++) if (wen[i]) regs[i] <= wdata_i;
    end
  end

  assign rdata_o = regs[raddr_i];
endmodule

// File: rtl/i2c_regfile_target.sv
`timescale 1ns/1ps
module i2c_regfile_target
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         NUM_REGS    = 16,
  parameter int         CLK_REGS    = 8,
  parameter int         SYNC_STAGES = 2,
  localparam int        PTR_W       = $clog2(NUM_REGS)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe_o,
  output logic hold_o
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;
  tgt_state_e st;
  logic [3:0] cnt;
  logic [7:0] shreg, txreg, rdata;
  logic [PTR_W-1:0] ptr;
  logic rw, mack, in_xfer, oe, we;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_o      (scl_s),
    .sda_o      (sda_s),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_ev),
    .stop_o     (stop_ev)
  );

  assign we = (st == ST_WDAT) && scl_fall && (cnt == 4'd8) && !start_ev && !stop_ev;

  i2c_tgt_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(8)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (ptr),
    .wdata_i (shreg),
    .raddr_i (ptr),
    .rdata_o (rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      shreg   <= '0;
      txreg   <= '0;
      ptr     <= '0;
      rw      <= 1'b0;
      mack    <= 1'b0;
      in_xfer <= 1'b0;
      oe      <= 1'b0;
    end else if (start_ev) begin
      st  <= ST_ADDR;
      cnt <= '0;
      oe  <= 1'b0;
    end else if (stop_ev) begin
      st      <= ST_IDLE;
      oe      <= 1'b0;
      in_xfer <= 1'b0;
    end else begin
      case (st)
        ST_ADDR, ST_WADR, ST_WDAT: begin
          if (scl_rise && cnt != 4'd8) begin
            shreg <= {shreg[6:0], sda_s};
            cnt   <= cnt + 4'd1;
          end else if (scl_fall && cnt == 4'd8) begin
            cnt <= '0;
            if (st == ST_ADDR) begin
              if (shreg[7:1] == DEV_ADDR) begin
                rw      <= shreg[0];
                oe      <= 1'b1;
                in_xfer <= 1'b1;
                st      <= ST_ADDR_ACK;
              end else begin
                st <= ST_IDLE;
              end
            end else if (st == ST_WADR) begin
              ptr <= shreg[PTR_W-1:0];
              oe  <= 1'b1;
              st  <= ST_WADR_ACK;
            end else begin
              oe <= 1'b1;
              st <= ST_WDAT_ACK;
            end
          end
        end
        ST_ADDR_ACK: if (scl_fall) begin
          if (rw) begin
            txreg <= rdata;
            oe    <= ~rdata[7];
            cnt   <= '0;
            st    <= ST_RDAT;
          end else begin
            oe <= 1'b0;
            st <= ST_WADR;
          end
        end
        ST_WADR_ACK: if (scl_fall) begin
          oe <= 1'b0;
          st <= ST_WDAT;
        end
        ST_WDAT_ACK: if (scl_fall) begin
          oe  <= 1'b0;
          ptr <= ptr + 1'b1;
          st  <= ST_WDAT;
        end
        ST_RDAT: if (scl_fall) begin
          if (cnt == 4'd7) begin
            oe  <= 1'b0;
            cnt <= '0;
            st  <= ST_RDAT_ACK;
          end else begin
            txreg <= {txreg[6:0], 1'b0};
            oe    <= ~txreg[6];
            cnt   <= cnt + 4'd1;
          end
        end
        ST_RDAT_ACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
            ptr  <= ptr + 1'b1;
          end else if (scl_fall) begin
            if (mack) begin
              txreg <= rdata;
              oe    <= ~rdata[7];
              cnt   <= '0;
              st    <= ST_RDAT;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = oe;
  assign hold_o   = in_xfer && (ptr < PTR_W'(CLK_REGS));
endmodule

// File: rtl/i2c_regfile_target_chk.sv
`timescale 1ns/1ps
module i2c_regfile_target_chk
  import i2c_tgt_pkg::*;
#(
  parameter int PTR_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             sda_oe_o,
  input logic             hold_o,
  input logic             scl_s,
  input logic             scl_fall,
  input logic             start_ev,
  input logic             stop_ev,
  input tgt_state_e       st,
  input logic [PTR_W-1:0] ptr,
  input logic             mack
);
  a_r10_drive_scl_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sda_oe_o != $past(sda_oe_o)) |-> (!$past(scl_s) || !sda_oe_o));

  a_r3_ptr_single_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ptr != $past(ptr)) && ($past(st) != ST_WADR)) |-> (ptr == PTR_W'($past(ptr) + 1'b1)));

  a_r6_start_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_ev |=> ((st == ST_ADDR) && !sda_oe_o));

  a_r7_stop_drops_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_ev && !start_ev) |=> !hold_o);

  a_r5_nack_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((st == ST_RDAT_ACK) && scl_fall && !mack && !start_ev && !stop_ev)
      |=> (!sda_oe_o && (st == ST_IDLE)));
endmodule

bind i2c_regfile_target i2c_regfile_target_chk #(.PTR_W(PTR_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sda_oe_o (sda_oe_o),
  .hold_o   (hold_o),
  .scl_s    (scl_s),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .st       (st),
  .ptr      (ptr),
  .mack     (mack)
);

// File: tb/i2c_regfile_target_bench.sv
`timescale 1ns/1ps
module i2c_regfile_target_bench;
  localparam int Q  = 8;
  localparam int WD = 150000;
  localparam logic [11:0] VEC [6] = '{12'h05A, 12'h3C3, 12'h7A5, 12'h8FF, 12'hB01, 12'h180};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_oe, hold;
  wire  sda_bus = sda_m & ~sda_oe;

  int checks = 0;
  int fails = 0;
  int viol = 0;
  logic [7:0] mem [16];
  logic [3:0] bptr = 4'h0;

  always #2.5 clk = ~clk;

  i2c_regfile_target u_i2c_regfile_target (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .scl_i    (scl_m),
    .sda_i    (sda_bus),
    .sda_oe_o (sda_oe),
    .hold_o   (hold)
  );

  // R10 monitor: drive may only assert while the bus clock is low
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && sda_oe && !oe_prev && scl_m) viol++;
    oe_prev <= sda_oe;
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = (sda_bus == 1'b0);
    wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic rd_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b[i] = sda_bus;
      wq(Q);
      scl_m = 1'b0;
    end
    wq(Q);
    sda_m = ~give_ack; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic write_one(input logic [3:0] wa, input logic [7:0] d);
    bit ack;
    bus_start();
    wr_byte(8'hD0, ack); chk(ack, "R1 write address ack", ack, 1);
    wr_byte({4'h0, wa}, ack); chk(ack, "R8 word address ack", ack, 1);
    wr_byte(d, ack); chk(ack, "R8 data ack", ack, 1);
    bus_stop();
    mem[wa] = d;
    bptr = wa + 4'h1;
  endtask

  task automatic read_one(input logic [3:0] wa, output logic [7:0] d);
    bit ack;
    bus_start();
    wr_byte(8'hD0, ack); chk(ack, "R1 write address ack", ack, 1);
    wr_byte({4'h0, wa}, ack); chk(ack, "R8 word address ack", ack, 1);
    bus_start();
    wr_byte(8'hD1, ack); chk(ack, "R1 read address ack", ack, 1);
    rd_byte(1'b0, d);
    bus_stop();
    bptr = wa + 4'h1;
  endtask

  task automatic run_tests();
    bit ack;
    logic [7:0] d;
    for (int i = 0; i < 16; i++) mem[i] = 8'h00;

    // R9 reset state
    wq(4);
    chk(sda_oe == 1'b0, "R9 sda released in reset", sda_oe, 0);
    chk(hold == 1'b0, "R9 hold low in reset", hold, 0);
    rst_n = 1'b1;
    wq(4);
    chk(sda_oe == 1'b0 && hold == 1'b0, "R9 idle after reset", {sda_oe, hold}, 0);
    bus_start();
    wr_byte(8'hD1, ack); chk(ack, "R1 read address ack", ack, 1);
    rd_byte(1'b0, d);
    bus_stop();
    chk(d == 8'h00, "R9 pointer and register 0 reset", d, 0);
    bptr = 4'h1;

    // R2 vector table: single writes, addressed readback
    for (int i = 0; i < 6; i++) begin
      write_one(VEC[i][11:8], VEC[i][7:0]);
      read_one(VEC[i][11:8], d);
      chk(d == VEC[i][7:0], "R2 stored byte readback", d, VEC[i][7:0]);
    end

    // R3 burst write crossing the wrap
    bus_start();
    wr_byte(8'hD0, ack); chk(ack, "R1 write address ack", ack, 1);
    wr_byte(8'h0E, ack); chk(ack, "R8 word address ack", ack, 1);
    wr_byte(8'h11, ack); chk(ack, "R8 data ack", ack, 1);
    wr_byte(8'h22, ack); chk(ack, "R8 data ack", ack, 1);
    wr_byte(8'h33, ack); chk(ack, "R8 data ack", ack, 1);
    bus_stop();
    mem[14] = 8'h11; mem[15] = 8'h22; mem[0] = 8'h33; bptr = 4'h1;

    // R4 read with no pointer write
    bus_start();
    wr_byte(8'hD1, ack);
    rd_byte(1'b0, d);
    bus_stop();
    chk(d == mem[bptr], "R4 read continues at held pointer", d, mem[bptr]);
    bptr = bptr + 4'h1;

    // R5 + R3 burst read across wrap, then NACK release
    bus_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h0E, ack);
    bus_start();
    wr_byte(8'hD1, ack);
    rd_byte(1'b1, d); chk(d == 8'h11, "R5 burst read byte 0", d, 8'h11);
    rd_byte(1'b1, d); chk(d == 8'h22, "R5 burst read byte 1", d, 8'h22);
    rd_byte(1'b0, d); chk(d == 8'h33, "R3 burst read after wrap", d, 8'h33);
    rd_byte(1'b0, d); chk(d == 8'hFF, "R5 SDA released after NACK", d, 8'hFF);
    bus_stop();
    bptr = 4'h1;

    // R1 foreign address ignored, pointer not reloaded
    bus_start();
    wr_byte(8'hA0, ack); chk(!ack, "R1 foreign address not acked", ack, 0);
    wr_byte(8'h05, ack); chk(!ack, "R1 bytes after foreign address ignored", ack, 0);
    bus_stop();
    bus_start();
    wr_byte(8'hD1, ack);
    rd_byte(1'b0, d);
    bus_stop();
    chk(d == mem[bptr], "R1 pointer untouched by foreign transfer", d, mem[bptr]);
    bptr = bptr + 4'h1;

    // R6 repeated START aborts a partial byte
    bus_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h08, ack);
    send_bits(8'hA0, 4);
    bus_start();
    wr_byte(8'hD1, ack); chk(ack, "R6 address after aborted byte acked", ack, 1);
    rd_byte(1'b0, d);
    bus_stop();
    chk(d == mem[8], "R6 read after repeated START", d, mem[8]);
    bptr = 4'h9;

    // R7 hold follows pointer range and STOP
    bus_start();
    wr_byte(8'hD0, ack);
    chk(hold == 1'b0, "R7 hold low with pointer 9", hold, 0);
    wr_byte(8'h06, ack);
    chk(hold == 1'b1, "R7 hold high with pointer 6", hold, 1);
    wr_byte(8'hAA, ack);
    chk(hold == 1'b1, "R7 hold high with pointer 7", hold, 1);
    wr_byte(8'hBB, ack);
    chk(hold == 1'b0, "R7 hold drops at pointer 8", hold, 0);
    bus_stop();
    mem[6] = 8'hAA; mem[7] = 8'hBB;
    bus_start();
    wr_byte(8'hD0, ack);
    wr_byte(8'h02, ack);
    chk(hold == 1'b1, "R7 hold high with pointer 2", hold, 1);
    bus_stop();
    wq(4);
    chk(hold == 1'b0, "R7 hold released by STOP", hold, 0);

    read_one(4'h7, d);
    chk(d == 8'hBB, "R2 burst write stored at pointer 7", d, 8'hBB);
    read_one(4'h6, d);
    chk(d == 8'hAA, "R2 burst write stored at pointer 6", d, 8'hAA);

    chk(viol == 0, "R10 drive asserted only with SCL low", viol, 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (WD) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", WD, 0);
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule